// File: doc/BRIEF.md
# PCIe Function Power-State Sequencer

This block follows the device power state of one PCIe function and orders the internal bring-up that comes after a fundamental reset. While the active-low reset pin is held low, the function sits in the reset state. When the pin is released, the block waits a set number of cycles and then raises an internal power-good. Power-good starts a reload of configuration from non-volatile memory. PHY reset is held until that reload returns. The returned bit decides whether APM wake-up is armed. Later, and from the same release point, the block grants link training and then, after a longer wait, permission to answer configuration requests.

Once bring-up is done, the function sits in D0 uninitialized. Decoded configuration writes move it on from there. A write to the memory-enable bit of the command register moves it to D0 active. A write of the D3 code to the power-state field moves it to D3 and asks the link for L1. A write of the D0 code returns it from D3 to D0 active and does not touch the NVM again.

The reset pin is synchronized inside the block. Every output is a register on the single clock.

The NVM reply uses a valid/ready pair. `nvm_rsp_ready` is high only while a reload is outstanding. A reply is taken on the clock edge where `nvm_rsp_valid` and `nvm_rsp_ready` are both high. The loader may hold `valid` for as long as it likes, and a `valid` shown while `ready` is low is dropped, not stored.

Top module: `pm_dstate_seq`

## Requirements
- R1: `dstate` uses this encoding: D0 uninitialized = 00, D0 active = 01, reset state = 10, D3 = 11. After `perst_n` goes low, the first rising clock edge puts these reset values on the outputs: `dstate`=10, `phy_rst`=1, and `int_pwrgd`, `wake_en`, `link_train_en`, `cfg_rsp_en`, `link_l1_req`, `nvm_load_req` and `nvm_rsp_ready` all 0.
- R2: `int_pwrgd` goes high on rising edge number CLKPR_CYC+SYNC_STAGES counted after `perst_n` rises, and it stays high until the next reset.
- R3: One edge after `int_pwrgd` rises, `nvm_load_req` pulses high for one cycle and `nvm_rsp_ready` goes high. Until the reply is taken, `phy_rst` stays 1 and `wake_en` stays 0.
- R4: On the edge where `nvm_rsp_valid` and `nvm_rsp_ready` are both high, `phy_rst` drops to 0, `wake_en` takes the value of `nvm_rsp_apm_wake`, and `nvm_rsp_ready` drops. A `valid` shown while `ready` is low has no effect.
- R5: The function leaves the reset state for D0 uninitialized one edge after the reply is taken, and at no earlier point.
- R6: `link_train_en` goes high on rising edge number TRAIN_CYC+SYNC_STAGES counted after `perst_n` rises.
- R7: `cfg_rsp_en` goes high on rising edge number RESP_CYC+SYNC_STAGES counted after `perst_n` rises. RESP_CYC must be greater than TRAIN_CYC, so `cfg_rsp_en` high always implies `link_train_en` high.
- R8: In D0 uninitialized, a command write with `cfg_cmd_mem_en`=1 moves the function to D0 active on the next edge. In D0 active, a command write with memory-enable 0 leaves the state unchanged.
- R9: From D0 uninitialized or D0 active, a power-state write of 11 moves the function to D3 and raises `link_l1_req` on the next edge. A power-state write takes priority over a command write in the same cycle.
- R10: From D3, a power-state write of 00 moves the function to D0 active on the next edge and drops `link_l1_req`. It does this without a new NVM request and leaves `phy_rst` and `wake_en` as they were.
- R11: The following have no effect on `dstate`: any configuration write in the reset state, a command write in D3, and power-state codes 01 and 10.
- R12: If `perst_n` falls again partway through bring-up, the outstanding NVM reload is dropped (`nvm_rsp_ready` falls) and every delay counter restarts from the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| perst_n | input | 1 | Fundamental reset, active low, asynchronous |
| cfg_pmcsr_wr | input | 1 | Strobe: a write to the power-management control/status register |
| cfg_pmcsr_pstate | input | 2 | Power-state field carried by that write |
| cfg_cmd_wr | input | 1 | Strobe: a write to the command register |
| cfg_cmd_mem_en | input | 1 | Memory-access-enable bit carried by that write |
| nvm_load_req | output | 1 | One-cycle pulse that starts an NVM reload |
| nvm_rsp_valid | input | 1 | NVM reply is present |
| nvm_rsp_ready | output | 1 | Sequencer is waiting for the NVM reply |
| nvm_rsp_apm_wake | input | 1 | APM wake-up bit carried by the reply |
| dstate | output | 2 | Current device power state |
| link_l1_req | output | 1 | Request for the link to enter L1 |
| int_pwrgd | output | 1 | Internal power-good |
| phy_rst | output | 1 | PHY reset, active high |
| wake_en | output | 1 | APM wake-up enable |
| link_train_en | output | 1 | Link training allowed |
| cfg_rsp_en | output | 1 | Configuration responses allowed |

## Verification
A counter that starts too early or too late moves the rise of `int_pwrgd`, `link_train_en` or `cfg_rsp_en`. That shift shows up on the exact edge where the requirement says the rise should happen, so the bench checks each of these signals one edge before its due edge and again on it.

A loader stuck in the wrong phase shows up one edge after power-good: either no request pulse appears, or `nvm_rsp_ready` is high when it should be low, or `phy_rst` is released before any reply has been taken.

A wrong D-state transition shows up on `dstate` one edge after the write that caused it. An ignored write is checked by reading `dstate` on the edge after that write and again later.

A reset that fails to clear the sequence shows up as `nvm_rsp_ready` still high, or `int_pwrgd` still high, one edge after `perst_n` falls.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;

  typedef enum logic [1:0] {
    DS_D0U = 2'b00,
    DS_D0A = 2'b01,
    DS_DR  = 2'b10,
    DS_D3  = 2'b11
  } dstate_e;

  typedef enum logic [1:0] {
    LD_IDLE = 2'b00,
    LD_WAIT = 2'b01,
    LD_DONE = 2'b10
  } ld_state_e;

  localparam logic [1:0] PS_CODE_D0 = 2'b00;
  localparam logic [1:0] PS_CODE_D3 = 2'b11;

  localparam int unsigned N_MILESTONES = 3;
  localparam int unsigned MS_PWRGD = 0;
  localparam int unsigned MS_TRAIN = 1;
  localparam int unsigned MS_RESP  = 2;

endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

  // R1
  sync_low_on_pin_chk: assert property (@(posedge clk) !arst_n |-> !srst_n)
    else $error("synchronized reset high while pin low");

endmodule

// File: rtl/pm_post_rst_timer.sv
module pm_post_rst_timer #(
  parameter int unsigned CLKPR_CYC = 4,
  parameter int unsigned TRAIN_CYC = 20,
  parameter int unsigned RESP_CYC  = 40
) (
  input  logic clk,
  input  logic rst_n,
  output logic pwrgd,
  output logic train_en,
  output logic rsp_en
);
  import pm_seq_pkg::*;

  localparam int unsigned MAX_A   = (CLKPR_CYC > TRAIN_CYC) ? CLKPR_CYC : TRAIN_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > RESP_CYC) ? MAX_A : RESP_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  function automatic int unsigned thr_sel(int unsigned idx);
    case (idx)
      MS_PWRGD: thr_sel = CLKPR_CYC;
      MS_TRAIN: thr_sel = TRAIN_CYC;
      default:  thr_sel = RESP_CYC;
    endcase
  endfunction

  logic [CW-1:0]           cnt_q;
  logic [N_MILESTONES-1:0] hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(MAX_CYC)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N_MILESTONES; g++) begin : g_ms
    localparam int unsigned THR = thr_sel(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hit_q[g] <= 1'b0;
      end else if (cnt_q == CW'(THR - 1)) begin
        hit_q[g] <= 1'b1;
      end
    end
  end

  assign pwrgd    = hit_q[MS_PWRGD];
  assign train_en = hit_q[MS_TRAIN];
  assign rsp_en   = hit_q[MS_RESP];

  // R2
  pwrgd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrgd |=> pwrgd) else $error("power-good dropped without reset");

  // R6
  train_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_en |=> train_en) else $error("training grant dropped without reset");

  // R7
  rsp_after_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_en |-> train_en) else $error("responses allowed before training");

endmodule

// File: rtl/pm_nvm_reload.sv
module pm_nvm_reload (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrgd,
  output logic load_req,
  input  logic rsp_valid,
  output logic rsp_ready,
  input  logic rsp_apm_wake,
  output logic phy_rst,
  output logic wake_en,
  output logic done
);
  import pm_seq_pkg::*;

  ld_state_e st_q;
  logic      take;

  assign take = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= LD_IDLE;
      load_req  <= 1'b0;
      rsp_ready <= 1'b0;
      phy_rst   <= 1'b1;
      wake_en   <= 1'b0;
      done      <= 1'b0;
    end else begin
      load_req <= 1'b0;
      unique case (st_q)
        LD_IDLE: begin
          if (pwrgd) begin
            st_q      <= LD_WAIT;
            load_req  <= 1'b1;
            rsp_ready <= 1'b1;
            phy_rst   <= 1'b1;
            wake_en   <= 1'b0;
          end
        end
        LD_WAIT: begin
          if (take) begin
            st_q      <= LD_DONE;
            rsp_ready <= 1'b0;
            phy_rst   <= 1'b0;
            wake_en   <= rsp_apm_wake;
            done      <= 1'b1;
          end
        end
        default: begin
          st_q <= LD_DONE;
        end
      endcase
    end
  end

  // R3
  load_after_pwrgd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> pwrgd) else $error("reload requested before power-good");

  // R3
  phy_held_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> (phy_rst && !wake_en)) else $error("PHY released during reload");

  // R4
  take_releases_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!phy_rst && !rsp_ready)) else $error("reply taken but PHY still held");

  // R4
  no_release_without_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rst && !take) |=> phy_rst) else $error("PHY released without a reply");

endmodule

// File: rtl/pm_dstate_fsm.sv
module pm_dstate_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bringup_done,
  input  logic       pmcsr_wr,
  input  logic [1:0] pmcsr_pstate,
  input  logic       cmd_wr,
  input  logic       cmd_mem_en,
  output logic [1:0] dstate,
  output logic       l1_req
);
  import pm_seq_pkg::*;

  dstate_e st_q, st_d;
  logic    ps_to_d3, ps_to_d0, mem_on;

  assign ps_to_d3 = pmcsr_wr && (pmcsr_pstate == PS_CODE_D3);
  assign ps_to_d0 = pmcsr_wr && (pmcsr_pstate == PS_CODE_D0);
  assign mem_on   = cmd_wr && cmd_mem_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      DS_DR: begin
        if (bringup_done) st_d = DS_D0U;
      end
      DS_D0U: begin
        if (ps_to_d3)    st_d = DS_D3;
        else if (mem_on) st_d = DS_D0A;
      end
      DS_D0A: begin
        if (ps_to_d3) st_d = DS_D3;
      end
      DS_D3: begin
        if (ps_to_d0) st_d = DS_D0A;
      end
      default: st_d = DS_DR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= DS_DR;
      l1_req <= 1'b0;
    end else begin
      st_q   <= st_d;
      l1_req <= (st_d == DS_D3);
    end
  end

  assign dstate = st_q;

  // R9
  d3_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_to_d3 && (st_q == DS_D0U || st_q == DS_D0A)) |=> (st_q == DS_D3 && l1_req))
    else $error("power-state write 11 did not enter D3");

  // R10
  d3_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DS_D3 && ps_to_d0) |=> (st_q == DS_D0A && !l1_req))
    else $error("power-state write 00 did not leave D3");

  // R11
  d3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DS_D3 && !ps_to_d0) |=> st_q == DS_D3)
    else $error("D3 left without a D0 write");

  // R5
  dr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DS_DR && !bringup_done) |=> st_q == DS_DR)
    else $error("reset state left before bring-up");

endmodule

// File: rtl/pm_dstate_seq.sv
module pm_dstate_seq #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CLKPR_CYC   = 4,
  parameter int unsigned TRAIN_CYC   = 20,
  parameter int unsigned RESP_CYC    = 40
) (
  input  logic       clk,
  input  logic       perst_n,
  input  logic       cfg_pmcsr_wr,
  input  logic [1:0] cfg_pmcsr_pstate,
  input  logic       cfg_cmd_wr,
  input  logic       cfg_cmd_mem_en,
  output logic       nvm_load_req,
  input  logic       nvm_rsp_valid,
  output logic       nvm_rsp_ready,
  input  logic       nvm_rsp_apm_wake,
  output logic [1:0] dstate,
  output logic       link_l1_req,
  output logic       int_pwrgd,
  output logic       phy_rst,
  output logic       wake_en,
  output logic       link_train_en,
  output logic       cfg_rsp_en
);
  import pm_seq_pkg::*;

  logic perst_sync_n;
  logic bringup_done;

  pm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (perst_n),
    .srst_n (perst_sync_n)
  );

  pm_post_rst_timer #(
    .CLKPR_CYC (CLKPR_CYC),
    .TRAIN_CYC (TRAIN_CYC),
    .RESP_CYC  (RESP_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (perst_sync_n),
    .pwrgd    (int_pwrgd),
    .train_en (link_train_en),
    .rsp_en   (cfg_rsp_en)
  );

  pm_nvm_reload u_reload (
    .clk          (clk),
    .rst_n        (perst_sync_n),
    .pwrgd        (int_pwrgd),
    .load_req     (nvm_load_req),
    .rsp_valid    (nvm_rsp_valid),
    .rsp_ready    (nvm_rsp_ready),
    .rsp_apm_wake (nvm_rsp_apm_wake),
    .phy_rst      (phy_rst),
    .wake_en      (wake_en),
    .done         (bringup_done)
  );

  pm_dstate_fsm u_fsm (
    .clk          (clk),
    .rst_n        (perst_sync_n),
    .bringup_done (bringup_done),
    .pmcsr_wr     (cfg_pmcsr_wr),
    .pmcsr_pstate (cfg_pmcsr_pstate),
    .cmd_wr       (cfg_cmd_wr),
    .cmd_mem_en   (cfg_cmd_mem_en),
    .dstate       (dstate),
    .l1_req       (link_l1_req)
  );

  // R1
  reset_values_chk: assert property (@(posedge clk)
    !perst_sync_n |=> (dstate == DS_DR && phy_rst && !int_pwrgd && !wake_en &&
                       !link_train_en && !cfg_rsp_en && !link_l1_req &&
                       !nvm_load_req && !nvm_rsp_ready))
    else $error("outputs not at reset values");

  // R3
  phy_needs_pwrgd_chk: assert property (@(posedge clk) disable iff (!perst_sync_n)
    !phy_rst |-> int_pwrgd) else $error("PHY out of reset without power-good");

  // R5
  active_needs_phy_chk: assert property (@(posedge clk) disable iff (!perst_sync_n)
    (dstate != DS_DR) |-> !phy_rst) else $error("left reset state with PHY held");

  // R4
  wake_needs_phy_chk: assert property (@(posedge clk) disable iff (!perst_sync_n)
    wake_en |-> !phy_rst) else $error("wake enabled while PHY held");

endmodule

// File: tb/pm_dstate_seq_tb.sv
module pm_dstate_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int T_PG = 4;
  localparam int T_TRN = 20;
  localparam int T_RSP = 40;
  localparam int WD_LIMIT = 5000;

  localparam logic [9:0] M_DS = 10'h300, M_PG = 10'h080, M_PHY = 10'h040,
    M_WAKE = 10'h020, M_TRN = 10'h010, M_RSP = 10'h008, M_L1 = 10'h004,
    M_REQ = 10'h002, M_RDY = 10'h001, M_ALL = 10'h3FF;
  localparam logic [9:0] V_RESET = 10'h240;
  localparam logic [1:0] DS_D0U = 2'b00, DS_D0A = 2'b01, DS_DR = 2'b10, DS_D3 = 2'b11;

  logic clk = 1'b0;
  logic perst_n = 1'b0;
  logic cfg_pmcsr_wr = 1'b0;
  logic [1:0] cfg_pmcsr_pstate = 2'b00;
  logic cfg_cmd_wr = 1'b0;
  logic cfg_cmd_mem_en = 1'b0;
  logic nvm_rsp_valid = 1'b0;
  logic nvm_rsp_apm_wake = 1'b0;
  logic nvm_load_req, nvm_rsp_ready, link_l1_req, int_pwrgd, phy_rst;
  logic wake_en, link_train_en, cfg_rsp_en;
  logic [1:0] dstate;
  logic [9:0] obs;
  int cyc = 0;
  int n_checks = 0;
  int n_fails = 0;

  typedef struct {
    int         at;
    logic [9:0] mask;
    logic [9:0] val;
    int         rid;
  } exp_t;
  exp_t sbq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pm_dstate_seq #(.SYNC_STAGES(SYNC), .CLKPR_CYC(T_PG), .TRAIN_CYC(T_TRN),
    .RESP_CYC(T_RSP)) u_dut (
    .clk(clk), .perst_n(perst_n), .cfg_pmcsr_wr(cfg_pmcsr_wr),
    .cfg_pmcsr_pstate(cfg_pmcsr_pstate), .cfg_cmd_wr(cfg_cmd_wr),
    .cfg_cmd_mem_en(cfg_cmd_mem_en), .nvm_load_req(nvm_load_req),
    .nvm_rsp_valid(nvm_rsp_valid), .nvm_rsp_ready(nvm_rsp_ready),
    .nvm_rsp_apm_wake(nvm_rsp_apm_wake), .dstate(dstate),
    .link_l1_req(link_l1_req), .int_pwrgd(int_pwrgd), .phy_rst(phy_rst),
    .wake_en(wake_en), .link_train_en(link_train_en), .cfg_rsp_en(cfg_rsp_en));

  assign obs = {dstate, int_pwrgd, phy_rst, wake_en, link_train_en, cfg_rsp_en,
                link_l1_req, nvm_load_req, nvm_rsp_ready};

  function automatic void expect_at(int at, logic [9:0] mask, logic [9:0] val, int rid);
    exp_t e;
    int pos;
    e.at = at; e.mask = mask; e.val = val; e.rid = rid;
    pos = sbq.size();
    for (int i = 0; i < sbq.size(); i++) begin
      if (sbq[i].at > at) begin
        pos = i;
        break;
      end
    end
    sbq.insert(pos, e);
  endfunction

  function automatic logic [9:0] ds_val(logic [1:0] d);
    return {d, 8'h00};
  endfunction

  task automatic wait_until(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run();
    while (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      n_checks++;
      n_fails++;
      $display("FAIL R%0d never compared: actual none expected %b at cycle %0d", e.rid, e.val, e.at);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // monitor: pops the expected items due this cycle and compares them
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      n_checks++;
      if (e.at < cyc || ((obs ^ e.val) & e.mask) != 10'h000) begin
        n_fails++;
        $display("FAIL R%0d cycle %0d: actual %b expected %b mask %b",
                 e.rid, cyc, obs & e.mask, e.val & e.mask, e.mask);
      end
    end
    if (cyc >= WD_LIMIT) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual cycle %0d expected end before %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    int c0, c1, c2, c3;
    // R1 reset state held from time zero
    expect_at(3, M_ALL, V_RESET, 1);
    wait_until(4);
    c0 = cyc;
    perst_n = 1'b1;

    // R2 power-good on edge T_PG+SYNC after release
    expect_at(c0 + SYNC + T_PG - 1, M_PG, 10'h000, 2);
    expect_at(c0 + SYNC + T_PG, M_PG, M_PG, 2);
    // R3 reload request pulse, ready held, PHY still in reset
    expect_at(c0 + SYNC + T_PG, M_REQ | M_RDY, 10'h000, 3);
    expect_at(c0 + 7, M_REQ | M_RDY | M_PHY | M_WAKE, M_REQ | M_RDY | M_PHY, 3);
    expect_at(c0 + 8, M_REQ | M_RDY | M_PHY, M_RDY | M_PHY, 3);
    // R11 writes in reset state ignored
    expect_at(c0 + 9, M_DS, ds_val(DS_DR), 11);
    expect_at(c0 + 10, M_DS | M_L1, ds_val(DS_DR), 11);
    // R4 reply taken: PHY out of reset, wake follows the bit
    expect_at(c0 + 11, M_PHY | M_WAKE | M_RDY | M_DS, M_WAKE | ds_val(DS_DR), 4);
    // R5 D0 uninitialized one edge later (and R11: not D0 active, not D3)
    expect_at(c0 + 12, M_DS | M_L1, ds_val(DS_D0U), 5);
    // R6 training grant
    expect_at(c0 + SYNC + T_TRN - 1, M_TRN, 10'h000, 6);
    expect_at(c0 + SYNC + T_TRN, M_TRN, M_TRN, 6);
    // R7 response permit
    expect_at(c0 + SYNC + T_RSP - 1, M_RSP, 10'h000, 7);
    expect_at(c0 + SYNC + T_RSP, M_RSP | M_TRN, M_RSP | M_TRN, 7);
    // R11 pstate 01 ignored
    expect_at(c0 + 46, M_DS, ds_val(DS_D0U), 11);
    // R9 D0u to D3
    expect_at(c0 + 48, M_DS | M_L1, ds_val(DS_D3) | M_L1, 9);
    // R11 command write in D3 ignored
    expect_at(c0 + 51, M_DS, ds_val(DS_D3), 11);
    // R10 back to D0 active without a reload
    expect_at(c0 + 53, M_ALL & ~(M_PG | M_TRN | M_RSP), ds_val(DS_D0A) | M_WAKE, 10);
    expect_at(c0 + 54, M_REQ | M_RDY | M_PHY, 10'h000, 10);
    // R9 D0a to D3
    expect_at(c0 + 56, M_DS | M_L1, ds_val(DS_D3) | M_L1, 9);

    wait_until(c0 + 3);
    nvm_rsp_valid = 1'b1; nvm_rsp_apm_wake = 1'b1;   // R4 valid without ready
    wait_until(c0 + 4);
    nvm_rsp_valid = 1'b0; nvm_rsp_apm_wake = 1'b0;
    wait_until(c0 + 8);
    cfg_cmd_wr = 1'b1; cfg_cmd_mem_en = 1'b1;
    wait_until(c0 + 9);
    cfg_cmd_wr = 1'b0; cfg_cmd_mem_en = 1'b0;
    cfg_pmcsr_wr = 1'b1; cfg_pmcsr_pstate = 2'b11;
    wait_until(c0 + 10);
    cfg_pmcsr_wr = 1'b0; cfg_pmcsr_pstate = 2'b00;
    nvm_rsp_valid = 1'b1; nvm_rsp_apm_wake = 1'b1;
    wait_until(c0 + 11);
    nvm_rsp_valid = 1'b0; nvm_rsp_apm_wake = 1'b0;
    wait_until(c0 + 45);
    cfg_pmcsr_wr = 1'b1; cfg_pmcsr_pstate = 2'b01;
    wait_until(c0 + 46);
    cfg_pmcsr_wr = 1'b0; cfg_pmcsr_pstate = 2'b00;
    wait_until(c0 + 47);
    cfg_pmcsr_wr = 1'b1; cfg_pmcsr_pstate = 2'b11;
    wait_until(c0 + 48);
    cfg_pmcsr_wr = 1'b0; cfg_pmcsr_pstate = 2'b00;
    wait_until(c0 + 50);
    cfg_cmd_wr = 1'b1; cfg_cmd_mem_en = 1'b1;
    wait_until(c0 + 51);
    cfg_cmd_wr = 1'b0; cfg_cmd_mem_en = 1'b0;
    wait_until(c0 + 52);
    cfg_pmcsr_wr = 1'b1; cfg_pmcsr_pstate = 2'b00;
    wait_until(c0 + 53);
    cfg_pmcsr_wr = 1'b0;
    wait_until(c0 + 55);
    cfg_pmcsr_wr = 1'b1; cfg_pmcsr_pstate = 2'b11;
    wait_until(c0 + 56);
    cfg_pmcsr_wr = 1'b0; cfg_pmcsr_pstate = 2'b00;

    // second phase: reset from D3, then an aborted bring-up
    c1 = c0 + 60;
    c2 = c1 + 3;
    c3 = c2 + 10;
    expect_at(c1 + 1, M_ALL, V_RESET, 1);                          // R1 from D3
    expect_at(c2 + SYNC + T_PG, M_PG, M_PG, 2);
    expect_at(c2 + 7, M_RDY | M_REQ, M_RDY | M_REQ, 3);
    expect_at(c2 + 9, M_RDY | M_REQ | M_PHY | M_DS | M_PG, M_PHY | ds_val(DS_DR), 12);  // R12 abort
    expect_at(c3 + SYNC + T_PG - 1, M_PG | M_RDY, 10'h000, 12);   // R12 timer restarted
    expect_at(c3 + SYNC + T_PG, M_PG, M_PG, 12);
    expect_at(c3 + 7, M_RDY | M_PHY, M_RDY | M_PHY, 3);
    expect_at(c3 + 10, M_PHY | M_WAKE | M_RDY, 10'h000, 4);        // R4 bit clear
    expect_at(c3 + 11, M_DS, ds_val(DS_D0U), 5);
    expect_at(c3 + 13, M_DS, ds_val(DS_D0A), 8);                   // R8 memory enable
    expect_at(c3 + 15, M_DS | M_L1, ds_val(DS_D0A), 8);            // R8 disable write kept
    expect_at(c3 + 17, M_DS | M_L1, ds_val(DS_D3) | M_L1, 9);      // R9 priority
    expect_at(c3 + SYNC + T_TRN - 1, M_TRN, 10'h000, 6);
    expect_at(c3 + SYNC + T_TRN, M_TRN, M_TRN, 6);
    expect_at(c3 + SYNC + T_RSP - 1, M_RSP, 10'h000, 7);
    expect_at(c3 + SYNC + T_RSP, M_RSP, M_RSP, 7);

    wait_until(c1);
    perst_n = 1'b0;
    wait_until(c2);
    perst_n = 1'b1;
    wait_until(c2 + 8);
    perst_n = 1'b0;
    wait_until(c3);
    perst_n = 1'b1;
    wait_until(c3 + 9);
    nvm_rsp_valid = 1'b1; nvm_rsp_apm_wake = 1'b0;
    wait_until(c3 + 10);
    nvm_rsp_valid = 1'b0;
    wait_until(c3 + 12);
    cfg_cmd_wr = 1'b1; cfg_cmd_mem_en = 1'b1;
    wait_until(c3 + 13);
    cfg_cmd_wr = 1'b0; cfg_cmd_mem_en = 1'b0;
    wait_until(c3 + 14);
    cfg_cmd_wr = 1'b1; cfg_cmd_mem_en = 1'b0;
    wait_until(c3 + 15);
    cfg_cmd_wr = 1'b0;
    wait_until(c3 + 16);
    cfg_pmcsr_wr = 1'b1; cfg_pmcsr_pstate = 2'b11;
    cfg_cmd_wr = 1'b1; cfg_cmd_mem_en = 1'b1;
    wait_until(c3 + 17);
    cfg_pmcsr_wr = 1'b0; cfg_pmcsr_pstate = 2'b00;
    cfg_cmd_wr = 1'b0; cfg_cmd_mem_en = 1'b0;

    wait_until(c3 + 50);
    @(negedge clk);
    finish_run();
  end

endmodule